// File: doc/BRIEF.md
# Load/Store Alignment and Extension Unit

This unit sits between a processor core and a byte-addressed data memory that is one word wide. For each of the eight load and store opcodes it adds a sign-extended 16-bit displacement to a base address. It then checks the result against the natural alignment of the access size. For an aligned access it drives a request with per-byte write strobes and a word-aligned address. Stores have their low byte or half-word moved into the addressed byte lanes. Loads have the addressed bytes picked out of the returned word and widened to a full word, with zero fill or sign fill chosen by the opcode.

The memory is little-endian and returns read data one cycle after an accepted request. A load result appears on the write-back port in the same cycle as the returned data. An access that breaks alignment sends no request, so nothing is written. It produces no write-back and raises a one-cycle fault flag one cycle after the request. Handling that fault is left to the rest of the core.

Top module: `ldst_align_unit`

## Requirements
- R1: The effective address is the base plus the sign-extended 16-bit offset, wrapping modulo 2^32. On every request, mem_addr carries that address with its two low bits cleared.
- R2: The strobe lanes depend on the low address bits a. A byte access drives mem_be = 4'b0001 << a[1:0]. A half-word drives 4'b0011 << (2*a[1]). A word drives 4'b1111. Loads use the same strobes.
- R3: A byte store (opcode 0x08) places source bits [7:0] in lane a[1:0]. A half-word store (0x09) places bits [15:0] in lanes starting at 2*a[1]. A word store (0x0A) passes the whole word. Lanes outside the strobe carry zero, and mem_we is high only for stores.
- R4: A half-word access with a[0]=1 is misaligned, and so is a word access with a[1:0]!=0. Byte accesses are never misaligned. A misaligned access drives no memory request, so memory is not written. It produces no write-back, and fault is high for exactly the following cycle.
- R5: Unsigned loads zero-fill bits above the loaded value. Opcode 0x03 loads a byte and opcode 0x05 loads a half-word.
- R6: Signed loads fill the upper bits with the loaded value's top bit. Opcode 0x04 loads a byte and opcode 0x06 loads a half-word.
- R7: A word load (opcode 0x07) returns the memory word unchanged.
- R8: Each aligned load gives exactly one wb_valid pulse, one cycle after the request, carrying the requested destination index on wb_rd. Stores, faulted accesses and idle cycles give no write-back. Back-to-back loads give back-to-back results.
- R9: An opcode outside 0x03 to 0x0A drives no request, no fault and no write-back. So does any cycle with req_valid low.
- R10: While rst is high, and in the first cycle after it falls, wb_valid and fault are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Access request this cycle |
| req_op | input | 8 | Opcode of the access |
| req_base | input | ADDR_W | Base address |
| req_offset | input | OFFS_W | Signed displacement |
| req_wdata | input | DATA_W | Store source register value |
| req_rd | input | RIDX_W | Destination register index for loads |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | ADDR_W | Word-aligned memory address |
| mem_be | output | DATA_W/8 | Byte strobes |
| mem_wdata | output | DATA_W | Lane-aligned store data |
| mem_rdata | input | DATA_W | Read data, one cycle after request |
| wb_valid | output | 1 | Load result valid |
| wb_rd | output | RIDX_W | Destination register index |
| wb_data | output | DATA_W | Extended load result |
| fault | output | 1 | Misalignment fault, one cycle after request |

## Verification
The bench builds the unit with its defaults: a 32-bit word, 32-bit addresses, a 16-bit displacement and 5-bit register indices. The 16-bit displacement lets negative offsets be tested on small bases. It also lets a base of zero with offset 0xFFFC reach the topmost word of the address space. With four byte lanes, every strobe position and every sign-fill source byte can be reached. Reading stores back through the same port shows that neighbouring lanes and blocked misaligned writes leave memory untouched.

// File: rtl/ldst_pkg.sv
package ldst_pkg;

    localparam logic [7:0] OP_LD_U8  = 8'h03;
    localparam logic [7:0] OP_LD_S8  = 8'h04;
    localparam logic [7:0] OP_LD_U16 = 8'h05;
    localparam logic [7:0] OP_LD_S16 = 8'h06;
    localparam logic [7:0] OP_LD_W   = 8'h07;
    localparam logic [7:0] OP_ST_8   = 8'h08;
    localparam logic [7:0] OP_ST_16  = 8'h09;
    localparam logic [7:0] OP_ST_W   = 8'h0A;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2
    } acc_size_e;

    typedef struct packed {
        logic      hit;    // opcode belongs to this unit
        logic      store;  // write access
        logic      sext;   // sign fill on load
        acc_size_e size;
    } acc_dec_t;

    function automatic acc_dec_t decode_op(input logic [7:0] op);
        acc_dec_t d;
        d = '{hit: 1'b0, store: 1'b0, sext: 1'b0, size: SZ_BYTE};
        case (op)
            OP_LD_U8:  d = '{hit: 1'b1, store: 1'b0, sext: 1'b0, size: SZ_BYTE};
            OP_LD_S8:  d = '{hit: 1'b1, store: 1'b0, sext: 1'b1, size: SZ_BYTE};
            OP_LD_U16: d = '{hit: 1'b1, store: 1'b0, sext: 1'b0, size: SZ_HALF};
            OP_LD_S16: d = '{hit: 1'b1, store: 1'b0, sext: 1'b1, size: SZ_HALF};
            OP_LD_W:   d = '{hit: 1'b1, store: 1'b0, sext: 1'b0, size: SZ_WORD};
            OP_ST_8:   d = '{hit: 1'b1, store: 1'b1, sext: 1'b0, size: SZ_BYTE};
            OP_ST_16:  d = '{hit: 1'b1, store: 1'b1, sext: 1'b0, size: SZ_HALF};
            OP_ST_W:   d = '{hit: 1'b1, store: 1'b1, sext: 1'b0, size: SZ_WORD};
            default:   d = '{hit: 1'b0, store: 1'b0, sext: 1'b0, size: SZ_BYTE};
        endcase
        return d;
    endfunction

endpackage

// File: rtl/ldst_addr_gen.sv
module ldst_addr_gen
    import ldst_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int OFFS_W = 16,
    parameter int LANES  = 4,
    localparam int LANE_W = $clog2(LANES)
) (
    input  logic [ADDR_W-1:0] base,
    input  logic [OFFS_W-1:0] offset,
    input  acc_size_e         size,
    output logic [ADDR_W-1:0] word_addr,
    output logic [LANE_W-1:0] lane,
    output logic [LANES-1:0]  strobe,
    output logic              misaligned
);

    logic [ADDR_W-1:0] ea;
    logic [ADDR_W-1:0] offset_ext;

    assign offset_ext = {{(ADDR_W-OFFS_W){offset[OFFS_W-1]}}, offset};
    assign ea         = base + offset_ext;
    assign lane       = ea[LANE_W-1:0];
    assign word_addr  = {ea[ADDR_W-1:LANE_W], {LANE_W{1'b0}}};

    always_comb begin
        strobe     = '0;
        misaligned = 1'b0;
        case (size)
            SZ_BYTE: begin
                strobe     = LANES'(1) << lane;
                misaligned = 1'b0;
            end
            SZ_HALF: begin
                strobe     = LANES'(3) << {lane[LANE_W-1:1], 1'b0};
                misaligned = lane[0];
            end
            SZ_WORD: begin
                strobe     = '1;
                misaligned = |lane;
            end
            default: begin
                strobe     = '0;
                misaligned = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/ldst_store_lanes.sv
module ldst_store_lanes
    import ldst_pkg::*;
#(
    parameter int DATA_W = 32,
    localparam int LANES  = DATA_W / 8,
    localparam int LANE_W = $clog2(LANES)
) (
    input  logic [DATA_W-1:0] src,
    input  acc_size_e         size,
    input  logic [LANE_W-1:0] lane,
    output logic [DATA_W-1:0] lanes_out
);

    logic [DATA_W-1:0] masked;

    always_comb begin
        case (size)
            SZ_BYTE: masked = {{(DATA_W-8){1'b0}}, src[7:0]};
            SZ_HALF: masked = {{(DATA_W-16){1'b0}}, src[15:0]};
            default: masked = src;
        endcase
    end

    // Half-word lanes are always even once alignment holds.
    assign lanes_out = masked << {lane, 3'b000};

endmodule

// File: rtl/ldst_load_extract.sv
module ldst_load_extract
    import ldst_pkg::*;
#(
    parameter int DATA_W = 32,
    localparam int LANES  = DATA_W / 8,
    localparam int LANE_W = $clog2(LANES)
) (
    input  logic [DATA_W-1:0] word_in,
    input  acc_size_e         size,
    input  logic              sext,
    input  logic [LANE_W-1:0] lane,
    output logic [DATA_W-1:0] value
);

    logic [7:0]  lane_byte [LANES];
    logic [7:0]  byte_sel;
    logic [15:0] half_sel;

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        assign lane_byte[i] = word_in[8*i +: 8];
    end

    assign byte_sel = lane_byte[lane];
    assign half_sel = {lane_byte[{lane[LANE_W-1:1], 1'b1}],
                       lane_byte[{lane[LANE_W-1:1], 1'b0}]};

    always_comb begin
        case (size)
            SZ_BYTE: value = {{(DATA_W-8){sext & byte_sel[7]}}, byte_sel};
            SZ_HALF: value = {{(DATA_W-16){sext & half_sel[15]}}, half_sel};
            default: value = word_in;
        endcase
    end

endmodule

// File: rtl/ldst_align_unit.sv
module ldst_align_unit
    import ldst_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 32,
    parameter int OFFS_W = 16,
    parameter int RIDX_W = 5,
    localparam int LANES  = DATA_W / 8,
    localparam int LANE_W = $clog2(LANES)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [7:0]        req_op,
    input  logic [ADDR_W-1:0] req_base,
    input  logic [OFFS_W-1:0] req_offset,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [RIDX_W-1:0] req_rd,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [LANES-1:0]  mem_be,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              wb_valid,
    output logic [RIDX_W-1:0] wb_rd,
    output logic [DATA_W-1:0] wb_data,
    output logic              fault
);

    acc_dec_t          dec;
    logic              active;
    logic [LANE_W-1:0] lane;
    logic              misal;

    // Load context held for the cycle in which data returns.
    logic              pend_ld;
    logic              pend_sext;
    acc_size_e         pend_size;
    logic [LANE_W-1:0] pend_lane;
    logic [RIDX_W-1:0] pend_rd;
    logic              fault_q;

    assign dec    = decode_op(req_op);
    assign active = req_valid & dec.hit;

    ldst_addr_gen #(
        .ADDR_W (ADDR_W),
        .OFFS_W (OFFS_W),
        .LANES  (LANES)
    ) u_addr (
        .base       (req_base),
        .offset     (req_offset),
        .size       (dec.size),
        .word_addr  (mem_addr),
        .lane       (lane),
        .strobe     (mem_be),
        .misaligned (misal)
    );

    ldst_store_lanes #(
        .DATA_W (DATA_W)
    ) u_store (
        .src       (req_wdata),
        .size      (dec.size),
        .lane      (lane),
        .lanes_out (mem_wdata)
    );

    assign mem_req = active & ~misal;
    assign mem_we  = mem_req & dec.store;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_ld <= 1'b0;
            fault_q <= 1'b0;
        end else begin
            pend_ld <= mem_req & ~dec.store;
            fault_q <= active & misal;
        end
    end

    always_ff @(posedge clk) begin
        pend_sext <= dec.sext;
        pend_size <= dec.size;
        pend_lane <= lane;
        pend_rd   <= req_rd;
    end

    ldst_load_extract #(
        .DATA_W (DATA_W)
    ) u_load (
        .word_in (mem_rdata),
        .size    (pend_size),
        .sext    (pend_sext),
        .lane    (pend_lane),
        .value   (wb_data)
    );

    assign wb_valid = pend_ld;
    assign wb_rd    = pend_rd;
    assign fault    = fault_q;

endmodule

// File: rtl/ldst_align_checker.sv
module ldst_align_checker
    import ldst_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 32,
    parameter int OFFS_W = 16,
    localparam int LANES  = DATA_W / 8,
    localparam int LANE_W = $clog2(LANES)
) (
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic [7:0]        req_op,
    input logic [ADDR_W-1:0] req_base,
    input logic [OFFS_W-1:0] req_offset,
    input logic              mem_req,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [LANES-1:0]  mem_be,
    input logic              wb_valid,
    input logic              fault
);

    logic [ADDR_W-1:0] ea;
    logic              is_half;
    logic              is_word;
    logic              is_known;

    assign ea       = req_base + {{(ADDR_W-OFFS_W){req_offset[OFFS_W-1]}}, req_offset};
    assign is_half  = (req_op == OP_LD_U16) || (req_op == OP_LD_S16) || (req_op == OP_ST_16);
    assign is_word  = (req_op == OP_LD_W) || (req_op == OP_ST_W);
    assign is_known = (req_op >= OP_LD_U8) && (req_op <= OP_ST_W);

    assert_word_addr_R1: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> (mem_addr[LANE_W-1:0] == '0)
                 && (mem_addr[ADDR_W-1:LANE_W] == ea[ADDR_W-1:LANE_W]));

    assert_strobe_count_R2: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> ($countones(mem_be) == 1 || $countones(mem_be) == 2
                     || $countones(mem_be) == LANES));

    assert_we_needs_req_R3: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> mem_req);

    assert_half_misal_block_R4: assert property (@(posedge clk) disable iff (rst)
        (req_valid && is_half && ea[0]) |-> !mem_req);

    assert_word_misal_block_R4: assert property (@(posedge clk) disable iff (rst)
        (req_valid && is_word && (ea[LANE_W-1:0] != '0)) |-> !mem_req);

    assert_misal_fault_R4: assert property (@(posedge clk) disable iff (rst)
        (req_valid && is_half && ea[0]) |=> fault);

    assert_wb_follows_load_R8: assert property (@(posedge clk) disable iff (rst)
        wb_valid |-> $past(mem_req && !mem_we));

    assert_fault_no_wb_R8: assert property (@(posedge clk) disable iff (rst)
        fault |-> !wb_valid);

    assert_unknown_quiet_R9: assert property (@(posedge clk) disable iff (rst)
        (!req_valid || !is_known) |-> !mem_req);

    assert_unknown_no_fault_R9: assert property (@(posedge clk) disable iff (rst)
        (!req_valid || !is_known) |=> !fault);

endmodule

bind ldst_align_unit ldst_align_checker #(
    .DATA_W (DATA_W),
    .ADDR_W (ADDR_W),
    .OFFS_W (OFFS_W)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .req_valid  (req_valid),
    .req_op     (req_op),
    .req_base   (req_base),
    .req_offset (req_offset),
    .mem_req    (mem_req),
    .mem_we     (mem_we),
    .mem_addr   (mem_addr),
    .mem_be     (mem_be),
    .wb_valid   (wb_valid),
    .fault      (fault)
);

// File: tb/ldst_align_unit_bench.sv
`timescale 1ns/1ps
module ldst_align_unit_bench;

    logic        clk = 1'b0;
    logic        rst;
    logic        req_valid;
    logic [7:0]  req_op;
    logic [31:0] req_base;
    logic [15:0] req_offset;
    logic [31:0] req_wdata;
    logic [4:0]  req_rd;
    logic        mem_req;
    logic        mem_we;
    logic [31:0] mem_addr;
    logic [3:0]  mem_be;
    logic [31:0] mem_wdata;
    logic [31:0] mem_rdata;
    logic        wb_valid;
    logic [4:0]  wb_rd;
    logic [31:0] wb_data;
    logic        fault;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    ldst_align_unit u_ldst_align_unit (
        .clk        (clk),
        .rst        (rst),
        .req_valid  (req_valid),
        .req_op     (req_op),
        .req_base   (req_base),
        .req_offset (req_offset),
        .req_wdata  (req_wdata),
        .req_rd     (req_rd),
        .mem_req    (mem_req),
        .mem_we     (mem_we),
        .mem_addr   (mem_addr),
        .mem_be     (mem_be),
        .mem_wdata  (mem_wdata),
        .mem_rdata  (mem_rdata),
        .wb_valid   (wb_valid),
        .wb_rd      (wb_rd),
        .wb_data    (wb_data),
        .fault      (fault)
    );

    // Little-endian word memory with one-cycle read latency.
    logic [31:0] mem [64];
    always @(posedge clk) begin
        if (mem_req) begin
            if (mem_we) begin
                for (int b = 0; b < 4; b++)
                    if (mem_be[b]) mem[mem_addr[7:2]][8*b +: 8] <= mem_wdata[8*b +: 8];
            end else begin
                mem_rdata <= mem[mem_addr[7:2]];
            end
        end
    end

    typedef struct packed {
        logic [7:0]  op;
        logic [31:0] base;
        logic [15:0] off;
        logic [31:0] wd;
        logic [4:0]  rd;
        logic        e_req;
        logic [3:0]  e_be;
        logic [31:0] e_wd;
        logic        e_flt;
        logic        e_wbv;
        logic [31:0] e_wb;
        logic [3:0]  tag;
    } vec_t;

    localparam int NV = 25;
    localparam vec_t VECS [NV] = '{
        '{8'h03, 32'h10, 16'hFFF4, 32'h0,        5'd1,  1'b1, 4'b0001, 32'h0,        1'b0, 1'b1, 32'h00000035, 4'd5},
        '{8'h04, 32'h03, 16'h0002, 32'h0,        5'd2,  1'b1, 4'b0010, 32'h0,        1'b0, 1'b1, 32'hFFFFFFC0, 4'd6},
        '{8'h03, 32'h05, 16'h0000, 32'h0,        5'd3,  1'b1, 4'b0010, 32'h0,        1'b0, 1'b1, 32'h000000C0, 4'd5},
        '{8'h05, 32'h06, 16'h0000, 32'h0,        5'd4,  1'b1, 4'b1100, 32'h0,        1'b0, 1'b1, 32'h00008A7F, 4'd5},
        '{8'h06, 32'h06, 16'h0000, 32'h0,        5'd5,  1'b1, 4'b1100, 32'h0,        1'b0, 1'b1, 32'hFFFF8A7F, 4'd6},
        '{8'h06, 32'h04, 16'h0000, 32'h0,        5'd6,  1'b1, 4'b0011, 32'h0,        1'b0, 1'b1, 32'hFFFFC035, 4'd6},
        '{8'h05, 32'h08, 16'hFFFC, 32'h0,        5'd7,  1'b1, 4'b0011, 32'h0,        1'b0, 1'b1, 32'h0000C035, 4'd5},
        '{8'h07, 32'h04, 16'h0000, 32'h0,        5'd8,  1'b1, 4'b1111, 32'h0,        1'b0, 1'b1, 32'h8A7FC035, 4'd7},
        '{8'h04, 32'h07, 16'hFFFF, 32'h0,        5'd9,  1'b1, 4'b0100, 32'h0,        1'b0, 1'b1, 32'h0000007F, 4'd6},
        '{8'h04, 32'h07, 16'h0000, 32'h0,        5'd10, 1'b1, 4'b1000, 32'h0,        1'b0, 1'b1, 32'hFFFFFF8A, 4'd6},
        '{8'h05, 32'h05, 16'h0000, 32'h0,        5'd11, 1'b0, 4'b0000, 32'h0,        1'b1, 1'b0, 32'h0,        4'd4},
        '{8'h07, 32'h06, 16'h0000, 32'h0,        5'd12, 1'b0, 4'b0000, 32'h0,        1'b1, 1'b0, 32'h0,        4'd4},
        '{8'h09, 32'h07, 16'h0000, 32'hFFFFFFFF, 5'd0,  1'b0, 4'b0000, 32'h0,        1'b1, 1'b0, 32'h0,        4'd4},
        '{8'h0A, 32'h12, 16'h0000, 32'hFFFFFFFF, 5'd0,  1'b0, 4'b0000, 32'h0,        1'b1, 1'b0, 32'h0,        4'd4},
        '{8'h08, 32'h0B, 16'h0000, 32'h123456AB, 5'd0,  1'b1, 4'b1000, 32'hAB000000, 1'b0, 1'b0, 32'h0,        4'd3},
        '{8'h09, 32'h0A, 16'h0000, 32'hDEAD1234, 5'd0,  1'b1, 4'b1100, 32'h12340000, 1'b0, 1'b0, 32'h0,        4'd3},
        '{8'h08, 32'h08, 16'h0000, 32'h777777CD, 5'd0,  1'b1, 4'b0001, 32'h000000CD, 1'b0, 1'b0, 32'h0,        4'd2},
        '{8'h0A, 32'h0C, 16'h0000, 32'hCAFEF00D, 5'd0,  1'b1, 4'b1111, 32'hCAFEF00D, 1'b0, 1'b0, 32'h0,        4'd3},
        '{8'h07, 32'h08, 16'h0000, 32'h0,        5'd13, 1'b1, 4'b1111, 32'h0,        1'b0, 1'b1, 32'h123400CD, 4'd3},
        '{8'h07, 32'h0C, 16'h0000, 32'h0,        5'd14, 1'b1, 4'b1111, 32'h0,        1'b0, 1'b1, 32'hCAFEF00D, 4'd7},
        '{8'h07, 32'h10, 16'h0000, 32'h0,        5'd15, 1'b1, 4'b1111, 32'h0,        1'b0, 1'b1, 32'h00000000, 4'd4},
        '{8'h07, 32'h00, 16'hFFFC, 32'h0,        5'd16, 1'b1, 4'b1111, 32'h0,        1'b0, 1'b1, 32'h5A5A0001, 4'd1},
        '{8'h0B, 32'h04, 16'h0000, 32'h0,        5'd17, 1'b0, 4'b0000, 32'h0,        1'b0, 1'b0, 32'h0,        4'd9},
        '{8'h00, 32'h04, 16'h0000, 32'h0,        5'd18, 1'b0, 4'b0000, 32'h0,        1'b0, 1'b0, 32'h0,        4'd9},
        '{8'h02, 32'h05, 16'h0000, 32'h0,        5'd19, 1'b0, 4'b0000, 32'h0,        1'b0, 1'b0, 32'h0,        4'd9}
    };

    function automatic string rname(input logic [3:0] n);
        case (n)
            4'd1:    return "R1";
            4'd2:    return "R2";
            4'd3:    return "R3";
            4'd4:    return "R4";
            4'd5:    return "R5";
            4'd6:    return "R6";
            4'd7:    return "R7";
            4'd8:    return "R8";
            4'd9:    return "R9";
            default: return "R10";
        endcase
    endfunction

    task automatic check(input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic drive(input logic v, input logic [7:0] op, input logic [31:0] base,
                         input logic [15:0] off, input logic [31:0] wd, input logic [4:0] rd);
        req_valid  = v;
        req_op     = op;
        req_base   = base;
        req_offset = off;
        req_wdata  = wd;
        req_rd     = rd;
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        logic [31:0] exp_addr;
        for (int i = 0; i < 64; i++) mem[i] = 32'h0;
        mem[1]    = 32'h8A7FC035;
        mem[63]   = 32'h5A5A0001;
        mem_rdata = 32'h0;
        rst = 1'b1;
        drive(1'b1, 8'h05, 32'h5, 16'h0, 32'h0, 5'd0);   // misaligned during reset
        repeat (3) @(negedge clk);
        // R10: reset holds outputs low
        check("R10", "fault in reset", {31'b0, fault}, 32'h0);
        check("R10", "wb_valid in reset", {31'b0, wb_valid}, 32'h0);
        drive(1'b0, 8'h00, 32'h0, 16'h0, 32'h0, 5'd0);
        rst = 1'b0;
        @(negedge clk);
        check("R10", "fault after reset", {31'b0, fault}, 32'h0);
        check("R10", "wb_valid after reset", {31'b0, wb_valid}, 32'h0);

        for (int i = 0; i < NV; i++) begin
            vec_t v;
            string t;
            v = VECS[i];
            t = rname(v.tag);
            drive(1'b1, v.op, v.base, v.off, v.wd, v.rd);
            #1;
            check(t, "mem_req", {31'b0, mem_req}, {31'b0, v.e_req});
            if (v.e_req) begin
                exp_addr = (v.base + {{16{v.off[15]}}, v.off}) & 32'hFFFFFFFC;
                check("R1", "mem_addr", mem_addr, exp_addr);
                check("R2", "mem_be", {28'b0, mem_be}, {28'b0, v.e_be});
                check("R3", "mem_we", {31'b0, mem_we},
                      {31'b0, (v.op >= 8'h08 && v.op <= 8'h0A)});
                if (v.op >= 8'h08) check("R3", "mem_wdata", mem_wdata, v.e_wd);
            end
            @(negedge clk);
            check(t, "fault", {31'b0, fault}, {31'b0, v.e_flt});
            check("R8", "wb_valid", {31'b0, wb_valid}, {31'b0, v.e_wbv});
            if (v.e_wbv) begin
                check(t, "wb_data", wb_data, v.e_wb);
                check("R8", "wb_rd", {27'b0, wb_rd}, {27'b0, v.rd});
            end
        end

        // R9: idle cycle with a load opcode present issues nothing
        drive(1'b0, 8'h07, 32'h4, 16'h0, 32'h0, 5'd3);
        #1;
        check("R9", "idle mem_req", {31'b0, mem_req}, 32'h0);
        @(negedge clk);
        check("R9", "idle wb_valid", {31'b0, wb_valid}, 32'h0);
        check("R9", "idle fault", {31'b0, fault}, 32'h0);

        // R8: back-to-back loads produce back-to-back results
        drive(1'b1, 8'h03, 32'h4, 16'h0, 32'h0, 5'd20);
        @(negedge clk);
        check("R8", "b2b first valid", {31'b0, wb_valid}, 32'h1);
        check("R8", "b2b first data", wb_data, 32'h00000035);
        check("R8", "b2b first rd", {27'b0, wb_rd}, 32'd20);
        drive(1'b1, 8'h07, 32'hC, 16'h0, 32'h0, 5'd21);
        @(negedge clk);
        check("R8", "b2b second valid", {31'b0, wb_valid}, 32'h1);
        check("R8", "b2b second data", wb_data, 32'hCAFEF00D);
        check("R8", "b2b second rd", {27'b0, wb_rd}, 32'd21);

        // R8: a store right after a load gives no write-back
        drive(1'b1, 8'h08, 32'h20, 16'h0, 32'h11, 5'd22);
        @(negedge clk);
        check("R8", "store wb_valid", {31'b0, wb_valid}, 32'h0);

        // R4: fault lasts one cycle only
        drive(1'b1, 8'h06, 32'h3, 16'h0, 32'h0, 5'd23);
        @(negedge clk);
        check("R4", "fault pulse", {31'b0, fault}, 32'h1);
        drive(1'b0, 8'h00, 32'h0, 16'h0, 32'h0, 5'd0);
        @(negedge clk);
        check("R4", "fault cleared", {31'b0, fault}, 32'h0);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule